// File: doc/BRIEF.md
# Locked-Rotor Protection Timer

This block guards a three-phase motor drive against a stalled rotor. It counts edges of a slow external oscillator tick while the drive is running and clears that count each time the Hall sensors report a full electrical revolution. If the rotor stops turning, the count reaches its detection limit and the block raises a protection flag that forces every high-side and low-side gate command low. The same counter then times a hold-off period, after which the protection drops by itself and detection starts again from zero.

The oscillator tick arrives asynchronously, so it is passed through a synchroniser and only its rising edges are counted. Three release events end protection early and clear the count: the control level falling below running level, a low thermistor input, and a change of the direction input. An active thermal shutdown freezes the count in place without clearing it.

The control is a three-state machine. ST_IDLE (drive off, count held at zero) goes to ST_WATCH when the run flag is high. ST_WATCH (detection) goes back to ST_IDLE on a release event or when the run flag drops, and goes to ST_LOCKED on the tick that completes the detection count. ST_LOCKED (protection active) goes to ST_IDLE on a release event, and on the tick that completes the hold-off count goes to ST_WATCH if the run flag is high, otherwise to ST_IDLE. Every transition clears the count.

Top module: `lock_guard`

## Requirements
- R1: After reset the protection flag is low, the gate outputs follow the gate inputs, and the count is zero.
- R2: In the running state, protection asserts on the 256th counted tick edge with no completed revolution in between; after 255 it is still low.
- R3: A revolution pulse clears the count; if a tick edge is counted in the same cycle, the clear wins.
- R4: While protection is high, all gate_hi_o and gate_lo_o bits are 0; otherwise each equals its gate input bit.
- R5: Once protection is active it releases by itself on the 2816th counted tick edge; detection then restarts from a zero count.
- R6: A one-cycle pulse on ctl_low_i, therm_low_i or dir_chg_i drops protection in the next cycle and clears the count.
- R7: While tsd_active_i is high, tick edges are not counted and the count keeps its value.
- R8: With run_i low, no tick is counted, and dropping run_i during detection clears the count.
- R9: The tick is synchronised through two register stages and counted once per rising edge: a tick held high for many cycles counts once, and a rising input edge is counted at the third clock edge after it.
- R10: Revolution pulses have no effect while protection is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | Asynchronous slow oscillator tick |
| rev_done_i | input | 1 | One-cycle pulse per completed electrical revolution |
| run_i | input | 1 | High while the motor is being driven |
| ctl_low_i | input | 1 | Control level below running threshold (release) |
| therm_low_i | input | 1 | Thermistor input low (release) |
| dir_chg_i | input | 1 | Direction input changed (release) |
| tsd_active_i | input | 1 | Thermal shutdown active (freezes the count) |
| gate_hi_i | input | PHASES | High-side gate commands from the modulator |
| gate_lo_i | input | PHASES | Low-side gate commands from the modulator |
| gate_hi_o | output | PHASES | Masked high-side gate commands |
| gate_lo_o | output | PHASES | Masked low-side gate commands |
| prot_o | output | 1 | Locked-rotor protection active |

## Verification
The assertions check on every cycle that the gates are masked whenever protection is up, that protection only rises from a full detection count and only falls after a full hold-off count or a release event, that release events, revolution pulses and a dropped run flag leave the count at zero, and that thermal shutdown keeps the count still. The exact tick counts of 256 and 2816, the restart from zero after an automatic release, the single count for a long-held tick and the synchroniser latency can only be shown by the bench's scenarios against its cycle-by-cycle reference model.

// File: rtl/lockprot_pkg.sv
package lockprot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WATCH  = 2'd1,
        ST_LOCKED = 2'd2
    } guard_state_t;
endpackage

// File: rtl/tick_edge.sv
module tick_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[s] <= 1'b0;
                end else if (s == 0) begin
                    sync_q[s] <= async_i;
                end else begin
                    sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign pulse_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lockprot_pkg::*;
#(
    parameter int DETECT_TICKS = 256,
    parameter int HOLD_TICKS   = 2816,
    parameter int CNT_W        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rev_i,
    input  logic             run_i,
    input  logic             release_i,
    input  logic             freeze_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             clr_o,
    output logic             inc_o,
    output logic             prot_o
);
    localparam logic [CNT_W-1:0] DET_LAST  = CNT_W'(DETECT_TICKS - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

    guard_state_t state_q, state_d;
    logic         advance;

    assign advance = tick_i & ~freeze_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter control
    always_comb begin
        state_d = state_q;
        clr_o   = 1'b0;
        inc_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clr_o = 1'b1;
                if (run_i) begin
                    state_d = ST_WATCH;
                end
            end
            ST_WATCH: begin
                if (release_i || !run_i) begin
                    clr_o   = 1'b1;
                    state_d = ST_IDLE;
                end else if (rev_i) begin
                    clr_o = 1'b1;
                end else if (advance) begin
                    if (cnt_i == DET_LAST) begin
                        clr_o   = 1'b1;
                        state_d = ST_LOCKED;
                    end else begin
                        inc_o = 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (release_i) begin
                    clr_o   = 1'b1;
                    state_d = ST_IDLE;
                end else if (advance) begin
                    if (cnt_i == HOLD_LAST) begin
                        clr_o   = 1'b1;
                        state_d = run_i ? ST_WATCH : ST_IDLE;
                    end else begin
                        inc_o = 1'b1;
                    end
                end
            end
            default: begin
                clr_o   = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        prot_o = (state_q == ST_LOCKED);
    end
endmodule

// File: rtl/lock_guard.sv
module lock_guard #(
    parameter int DETECT_TICKS = 256,
    parameter int HOLD_TICKS   = 2816,
    parameter int SYNC_STAGES  = 2,
    parameter int PHASES       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick_i,
    input  logic              rev_done_i,
    input  logic              run_i,
    input  logic              ctl_low_i,
    input  logic              therm_low_i,
    input  logic              dir_chg_i,
    input  logic              tsd_active_i,
    input  logic [PHASES-1:0] gate_hi_i,
    input  logic [PHASES-1:0] gate_lo_i,
    output logic [PHASES-1:0] gate_hi_o,
    output logic [PHASES-1:0] gate_lo_o,
    output logic              prot_o
);
    localparam int MAX_TICKS = (HOLD_TICKS > DETECT_TICKS) ? HOLD_TICKS : DETECT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS);

    logic             tick_pulse;
    logic             release_any;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] tick_cnt;

    assign release_any = ctl_low_i | therm_low_i | dir_chg_i;

    tick_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (osc_tick_i),
        .pulse_o (tick_pulse)
    );

    stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (tick_cnt)
    );

    lock_fsm #(
        .DETECT_TICKS (DETECT_TICKS),
        .HOLD_TICKS   (HOLD_TICKS),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_pulse),
        .rev_i     (rev_done_i),
        .run_i     (run_i),
        .release_i (release_any),
        .freeze_i  (tsd_active_i),
        .cnt_i     (tick_cnt),
        .clr_o     (cnt_clr),
        .inc_o     (cnt_inc),
        .prot_o    (prot_o)
    );

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_mask
            assign gate_hi_o[p] = gate_hi_i[p] & ~prot_o;
            assign gate_lo_o[p] = gate_lo_i[p] & ~prot_o;
        end
    endgenerate
endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk #(
    parameter int DETECT_TICKS = 256,
    parameter int HOLD_TICKS   = 2816,
    parameter int PHASES       = 3,
    parameter int CNT_W        = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rev_done_i,
    input logic              run_i,
    input logic              ctl_low_i,
    input logic              therm_low_i,
    input logic              dir_chg_i,
    input logic              tsd_active_i,
    input logic [PHASES-1:0] gate_hi_o,
    input logic [PHASES-1:0] gate_lo_o,
    input logic              prot_o,
    input logic [CNT_W-1:0]  cnt
);
    logic rel;
    assign rel = ctl_low_i | therm_low_i | dir_chg_i;

    assert_gate_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_o |-> (gate_hi_o == '0 && gate_lo_o == '0));

    assert_lock_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_o) |-> ($past(cnt) == CNT_W'(DETECT_TICKS - 1)));

    assert_auto_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(prot_o) && !$past(rel)) |-> ($past(cnt) == CNT_W'(HOLD_TICKS - 1)));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> (!prot_o && cnt == '0));

    assert_rev_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_done_i && run_i && !prot_o && !rel) |=> (cnt == '0));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tsd_active_i && !rel && !rev_done_i && run_i) |=> $stable(cnt));

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !prot_o) |=> (cnt == '0 && !prot_o));
endmodule

bind lock_guard lock_guard_chk #(
    .DETECT_TICKS (DETECT_TICKS),
    .HOLD_TICKS   (HOLD_TICKS),
    .PHASES       (PHASES),
    .CNT_W        (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rev_done_i   (rev_done_i),
    .run_i        (run_i),
    .ctl_low_i    (ctl_low_i),
    .therm_low_i  (therm_low_i),
    .dir_chg_i    (dir_chg_i),
    .tsd_active_i (tsd_active_i),
    .gate_hi_o    (gate_hi_o),
    .gate_lo_o    (gate_lo_o),
    .prot_o       (prot_o),
    .cnt          (tick_cnt)
);

// File: tb/test_lock_guard.sv
`timescale 1ns/1ps
module test_lock_guard;
    localparam int DET  = 256;
    localparam int HOLD = 2816;
    localparam int PH   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick_i = 1'b0;
    logic          rev_done_i = 1'b0;
    logic          run_i = 1'b0;
    logic          ctl_low_i = 1'b0;
    logic          therm_low_i = 1'b0;
    logic          dir_chg_i = 1'b0;
    logic          tsd_active_i = 1'b0;
    logic [PH-1:0] gate_hi_i = '0;
    logic [PH-1:0] gate_lo_i = '0;
    logic [PH-1:0] gate_hi_o;
    logic [PH-1:0] gate_lo_o;
    logic          prot_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    lock_guard #(.DETECT_TICKS(DET), .HOLD_TICKS(HOLD), .SYNC_STAGES(2), .PHASES(PH)) i_lock_guard (
        .clk, .rst_n, .osc_tick_i, .rev_done_i, .run_i, .ctl_low_i, .therm_low_i,
        .dir_chg_i, .tsd_active_i, .gate_hi_i, .gate_lo_i, .gate_hi_o, .gate_lo_o, .prot_o
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0 idle, 1 watching, 2 locked
    int mstate = 0;
    int mcnt   = 0;
    bit hist[$] = '{0, 0, 0};

    always @(posedge clk) begin
        bit pulse;
        bit rel;
        if (!rst_n) begin
            mstate = 0; mcnt = 0; hist = '{0, 0, 0};
        end else begin
            pulse = hist[1] & ~hist[2];
            rel = ctl_low_i | therm_low_i | dir_chg_i;
            if (tsd_active_i) pulse = 0;
            case (mstate)
                0: begin mcnt = 0; if (run_i) mstate = 1; end
                1: begin
                    if (rel || !run_i) begin mcnt = 0; mstate = 0; end
                    else if (rev_done_i) mcnt = 0;
                    else if (pulse) begin
                        mcnt++;
                        if (mcnt == DET) begin mcnt = 0; mstate = 2; end
                    end
                end
                default: begin
                    if (rel) begin mcnt = 0; mstate = 0; end
                    else if (pulse) begin
                        mcnt++;
                        if (mcnt == HOLD) begin mcnt = 0; mstate = run_i ? 1 : 0; end
                    end
                end
            endcase
            hist.push_front(osc_tick_i);
            void'(hist.pop_back());
        end
    end

    // compare against the model once per clock, away from the edges
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit mp;
            mp = (mstate == 2);
            chk(prot_o == mp, "R2 R5 model prot", prot_o, mp);
            chk(gate_hi_o == (mp ? '0 : gate_hi_i), "R4 model gate_hi", gate_hi_o, mp ? 0 : gate_hi_i);
            chk(gate_lo_o == (mp ? '0 : gate_lo_i), "R4 model gate_lo", gate_lo_o, mp ? 0 : gate_lo_i);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_tick_i = 1'b1;
            cyc(2);        osc_tick_i = 1'b0;
            cyc(1);
        end
        #1;
    endtask

    task automatic pulse_rel(input int which);
        @(negedge clk);
        case (which)
            0: ctl_low_i = 1'b1;
            1: therm_low_i = 1'b1;
            default: dir_chg_i = 1'b1;
        endcase
        @(negedge clk);
        ctl_low_i = 1'b0; therm_low_i = 1'b0; dir_chg_i = 1'b0;
        #1;
    endtask

    task automatic lock_up();
        ticks(DET);
        chk(prot_o == 1'b1, "R2 lock reached", prot_o, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        gate_hi_i = 3'b101; gate_lo_i = 3'b010;
        cyc(3); #1;
        chk(prot_o == 1'b0, "R1 reset prot", prot_o, 0);
        chk(gate_hi_o == 3'b101, "R1 reset gate_hi", gate_hi_o, 5);
        @(negedge clk); rst_n = 1'b1;

        // R8: not running, ticks ignored
        ticks(300);
        chk(prot_o == 1'b0, "R8 ticks while idle", prot_o, 0);

        @(negedge clk); run_i = 1'b1;
        // R2 exact threshold
        ticks(DET - 1);
        chk(prot_o == 1'b0, "R2 after 255", prot_o, 0);
        ticks(1);
        chk(prot_o == 1'b1, "R2 after 256", prot_o, 1);
        chk(gate_hi_o == '0 && gate_lo_o == '0, "R4 masked", {gate_hi_o, gate_lo_o}, 0);

        // R5 hold-off exactly 2816, with R10 rev pulse ignored midway
        ticks(1000);
        @(negedge clk); rev_done_i = 1'b1; @(negedge clk); rev_done_i = 1'b0;
        ticks(HOLD - 1001);
        chk(prot_o == 1'b1, "R5 R10 after 2815", prot_o, 1);
        ticks(1);
        chk(prot_o == 1'b0, "R5 after 2816", prot_o, 0);
        chk(gate_lo_o == 3'b010, "R4 gates pass", gate_lo_o, 2);
        ticks(DET - 1);
        chk(prot_o == 1'b0, "R5 restart from zero", prot_o, 0);

        // R3 revolution clears, also when coincident with a counted tick
        @(negedge clk); rev_done_i = 1'b1; @(negedge clk); rev_done_i = 1'b0;
        ticks(200);
        @(negedge clk); osc_tick_i = 1'b1; cyc(2); rev_done_i = 1'b1;
        @(negedge clk); rev_done_i = 1'b0; osc_tick_i = 1'b0; cyc(1);
        ticks(DET - 1);
        chk(prot_o == 1'b0, "R3 coincident clear", prot_o, 0);
        ticks(1);
        chk(prot_o == 1'b1, "R3 locks after fresh 256", prot_o, 1);

        // R6 each release source
        pulse_rel(0);
        chk(prot_o == 1'b0, "R6 ctl_low release", prot_o, 0);
        lock_up();
        pulse_rel(1);
        chk(prot_o == 1'b0, "R6 therm_low release", prot_o, 0);
        lock_up();
        pulse_rel(2);
        chk(prot_o == 1'b0, "R6 dir_chg release", prot_o, 0);
        ticks(100);
        pulse_rel(2);
        ticks(200);
        chk(prot_o == 1'b0, "R6 count cleared", prot_o, 0);
        pulse_rel(0);

        // R7 thermal freeze
        ticks(100);
        @(negedge clk); tsd_active_i = 1'b1;
        ticks(500);
        chk(prot_o == 1'b0, "R7 frozen", prot_o, 0);
        @(negedge clk); tsd_active_i = 1'b0;
        ticks(DET - 101);
        chk(prot_o == 1'b0, "R7 kept count 255", prot_o, 0);
        ticks(1);
        chk(prot_o == 1'b1, "R7 kept count 256", prot_o, 1);
        pulse_rel(1);

        // R8 dropping run clears
        ticks(100);
        @(negedge clk); run_i = 1'b0; @(negedge clk); run_i = 1'b1;
        ticks(200);
        chk(prot_o == 1'b0, "R8 run drop cleared", prot_o, 0);
        pulse_rel(0);

        // R9 held-high tick counts once, and synchroniser latency
        ticks(DET - 2);
        @(negedge clk); osc_tick_i = 1'b1; cyc(50); osc_tick_i = 1'b0; cyc(3); #1;
        chk(prot_o == 1'b0, "R9 held tick counted once", prot_o, 0);
        @(negedge clk); osc_tick_i = 1'b1;
        cyc(2); #1;
        chk(prot_o == 1'b0, "R9 not yet after two edges", prot_o, 0);
        cyc(1); #1;
        chk(prot_o == 1'b1, "R9 counted at third edge", prot_o, 1);
        osc_tick_i = 1'b0;
        cyc(4);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule